// File: doc/BRIEF.md
# Outbound Address Window Translator

This block turns host-side memory addresses into PCIe bus addresses. A small set of programmable window pairs sits behind a 32-bit register port. Each pair has a range value and a map value. The range value carries the window base in host space, an enable flag and a size selector. The map value carries the matching PCIe base. Every range and map value is 64 bits wide.

An incoming host address first has a fixed host offset subtracted from it. The result is compared against all enabled windows in parallel. On a hit, the bits of the adjusted address above the window size are replaced by the map base. The low bits inside the window pass through unchanged. A miss raises a flag and drives a zero address.

Each pair offers a short list of power-of-two window sizes, starting at 128 MiB. By default pairs 0 and 1 offer two sizes and pairs 2 and 3 offer four. The translate port answers one clock after a request. The block does not forward transactions.

Top module: `ob_addr_xlate`

## Requirements
- R1: After reset, every register reads zero, no window is enabled, and xl_valid_o, xl_hit_o, xl_miss_o, xl_win_o and xl_addr_o are all zero.
- R2: Register word address = pair*4 + word. Word 0 is range bits [31:0], word 1 is range bits [63:32], word 2 is map bits [31:0] and word 3 is map bits [63:32]. A write stores all 32 bits. A read returns the stored word combinationally. Writing one word leaves the other words unchanged.
- R3: In the range value, bit 0 enables the window and bits [2:1] select the size: 128 MiB shifted left by the select value. A write to word 0 changes the enable bit from the next clock edge on. Writes to any other word leave the enable bit alone.
- R4: The parameter HOST_OFFSET (default 0x8000_0000) is subtracted from xl_addr_i before comparison. An address below HOST_OFFSET never hits.
- R5: A window hits when the adjusted address equals the range base in every bit at or above log2 of the window size, including bits [63:32]. Range bits below the window size are ignored, so a misaligned base is treated as aligned.
- R6: On a hit, xl_addr_o = (map bits at or above the window size) OR (adjusted-address bits below the window size). Map bits below the window size are ignored.
- R7: Pairs 0 and 1 accept size selects 0 and 1 (128 and 256 MiB). Pairs 2 and 3 accept selects 0 to 3 (128 MiB to 1 GiB). An enabled window whose select is outside its pair's list never hits.
- R8: When several windows hit, the lowest-numbered pair wins. xl_win_o reports that pair's index.
- R9: On a miss, xl_miss_o = 1, xl_hit_o = 0, xl_win_o = 0 and xl_addr_o = 0. xl_hit_o and xl_miss_o are never both high.
- R10: Each request with xl_valid_i high gives a result one cycle later, with xl_valid_o high. A cycle with no request gives xl_valid_o, xl_hit_o and xl_miss_o low one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| xl_valid_i | input | 1 | Translate request |
| xl_addr_i | input | 64 | Host address to translate |
| xl_valid_o | output | 1 | Result valid, one cycle after the request |
| xl_hit_o | output | 1 | Address fell in an enabled window |
| xl_miss_o | output | 1 | No window matched |
| xl_win_o | output | 2 | Index of the winning pair |
| xl_addr_o | output | 64 | Translated PCIe address, zero on a miss |

## Verification
The assertions assume that reg_addr_i, reg_we_i and xl_valid_i are never unknown once reset is released. They also assume that a register write and a translate request landing on the same edge see the state from before that write. The stimulus keeps within this by driving every input only on the falling clock edge. It holds each strobe for exactly one rising edge and issues a translate only after the window write it depends on has completed. Window contents are rewritten high word first, so no half-written window is enabled while a request is in flight.

// File: rtl/ob_xlate_pkg.sv
package ob_xlate_pkg;
  typedef enum logic [1:0] {
    W_RANGE_LO = 2'd0,
    W_RANGE_HI = 2'd1,
    W_MAP_LO   = 2'd2,
    W_MAP_HI   = 2'd3
  } word_sel_e;

  localparam int unsigned EN_BIT  = 0;
  localparam int unsigned SEL_LSB = 1;
endpackage

// File: rtl/ob_win_regs.sv
module ob_win_regs
  import ob_xlate_pkg::*;
#(
  parameter int unsigned NUM_WIN = 4,
  parameter int unsigned ADDR_W  = 64,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned REG_AW  = 4
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              we_i,
  input  logic [REG_AW-1:0]                 addr_i,
  input  logic [DATA_W-1:0]                 wdata_i,
  output logic [DATA_W-1:0]                 rdata_o,
  output logic [NUM_WIN-1:0][ADDR_W-1:0]    range_o,
  output logic [NUM_WIN-1:0][ADDR_W-1:0]    map_o
);
  // Each 64-bit value is two register words (ADDR_W == 2*DATA_W)
  localparam int unsigned PAIR_W = REG_AW - 2;

  logic [NUM_WIN-1:0][ADDR_W-1:0] range_q, map_q;
  logic [PAIR_W-1:0] pair_idx;
  logic              pair_ok;
  word_sel_e         word_sel;

  assign pair_idx = addr_i[REG_AW-1:2];
  assign pair_ok  = 32'(pair_idx) < NUM_WIN;
  assign word_sel = word_sel_e'(addr_i[1:0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      range_q <= '0;
      map_q   <= '0;
    end else if (we_i && pair_ok) begin
      unique case (word_sel)
        W_RANGE_LO: range_q[pair_idx][DATA_W-1:0]      <= wdata_i;
        W_RANGE_HI: range_q[pair_idx][ADDR_W-1:DATA_W] <= wdata_i;
        W_MAP_LO:   map_q[pair_idx][DATA_W-1:0]        <= wdata_i;
        W_MAP_HI:   map_q[pair_idx][ADDR_W-1:DATA_W]   <= wdata_i;
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    if (pair_ok) begin
      unique case (word_sel)
        W_RANGE_LO: rdata_o = range_q[pair_idx][DATA_W-1:0];
        W_RANGE_HI: rdata_o = range_q[pair_idx][ADDR_W-1:DATA_W];
        W_MAP_LO:   rdata_o = map_q[pair_idx][DATA_W-1:0];
        W_MAP_HI:   rdata_o = map_q[pair_idx][ADDR_W-1:DATA_W];
      endcase
    end
  end

  assign range_o = range_q;
  assign map_o   = map_q;

  for (genvar p = 0; p < NUM_WIN; p++) begin : g_chk
    assert_en_update_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && pair_ok && pair_idx == PAIR_W'(p) && word_sel == W_RANGE_LO)
      |=> (range_q[p][EN_BIT] == $past(wdata_i[EN_BIT])));

    assert_en_kept_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!(we_i && pair_idx == PAIR_W'(p) && word_sel == W_RANGE_LO))
      |=> $stable(range_q[p][EN_BIT]));
  end
endmodule

// File: rtl/ob_win_match.sv
module ob_win_match
  import ob_xlate_pkg::*;
#(
  parameter int unsigned ADDR_W   = 64,
  parameter int unsigned MIN_LOG2 = 27,
  parameter int unsigned SEL_W    = 2,
  parameter int unsigned NSIZES   = 4
) (
  input  logic [ADDR_W-1:0] range_i,
  input  logic [ADDR_W-1:0] map_i,
  input  logic [ADDR_W-1:0] adj_addr_i,
  input  logic              adj_ok_i,
  output logic              match_o,
  output logic [ADDR_W-1:0] xl_addr_o
);
  logic [SEL_W-1:0]  sel;
  logic              sel_ok;
  logic [ADDR_W-1:0] low_mask;

  assign sel      = range_i[SEL_LSB +: SEL_W];
  assign sel_ok   = 32'(sel) < NSIZES;
  // Bits inside the window; control bits always fall below MIN_LOG2
  assign low_mask = (ADDR_W'(1) << (MIN_LOG2 + 32'(sel))) - ADDR_W'(1);

  assign match_o   = range_i[EN_BIT] && sel_ok && adj_ok_i &&
                     ((adj_addr_i & ~low_mask) == (range_i & ~low_mask));
  assign xl_addr_o = (map_i & ~low_mask) | (adj_addr_i & low_mask);
endmodule

// File: rtl/ob_hit_pick.sv
module ob_hit_pick #(
  parameter int unsigned NUM_WIN = 4,
  parameter int unsigned ADDR_W  = 64,
  parameter int unsigned WIN_W   = 2
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [NUM_WIN-1:0]             match_i,
  input  logic [NUM_WIN-1:0][ADDR_W-1:0] addr_i,
  output logic                           hit_o,
  output logic [WIN_W-1:0]               win_o,
  output logic [ADDR_W-1:0]              addr_o
);
  logic [NUM_WIN-1:0] grant;
  logic               found;

  always_comb begin
    grant = '0;
    found = 1'b0;
    win_o = '0;
    for (int i = 0; i < NUM_WIN; i++) begin
      if (match_i[i] && !found) begin
        grant[i] = 1'b1;
        found    = 1'b1;
        win_o    = WIN_W'(i);
      end
    end
  end

  always_comb begin
    addr_o = '0;
    for (int i = 0; i < NUM_WIN; i++) addr_o |= addr_i[i] & {ADDR_W{grant[i]}};
  end

  assign hit_o = |match_i;

  assert_grant_onehot_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant) && ((grant != '0) == hit_o));

  for (genvar i = 0; i < NUM_WIN; i++) begin : g_prio
    localparam logic [NUM_WIN-1:0] BELOW = NUM_WIN'((64'd1 << i) - 64'd1);
    assert_grant_lowest_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      grant[i] |-> (match_i[i] && (match_i & BELOW) == '0));
  end
endmodule

// File: rtl/ob_addr_xlate.sv
module ob_addr_xlate #(
  parameter int unsigned              NUM_WIN     = 4,
  parameter int unsigned              ADDR_W      = 64,
  parameter int unsigned              DATA_W      = 32,
  parameter logic [ADDR_W-1:0]        HOST_OFFSET = 64'h0000_0000_8000_0000,
  parameter int unsigned              MIN_LOG2    = 27,
  parameter int unsigned              MAX_SIZES   = 4,
  parameter int unsigned              PAIR_NSIZES [NUM_WIN] = '{2, 2, 4, 4},
  localparam int unsigned             REG_AW      = $clog2(NUM_WIN * 4),
  localparam int unsigned             SEL_W       = $clog2(MAX_SIZES),
  localparam int unsigned             WIN_W       = $clog2(NUM_WIN)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              xl_valid_i,
  input  logic [ADDR_W-1:0] xl_addr_i,
  output logic              xl_valid_o,
  output logic              xl_hit_o,
  output logic              xl_miss_o,
  output logic [WIN_W-1:0]  xl_win_o,
  output logic [ADDR_W-1:0] xl_addr_o
);
  logic [NUM_WIN-1:0][ADDR_W-1:0] range_w, map_w, cand_addr;
  logic [NUM_WIN-1:0]             match;
  logic [ADDR_W:0]                diff;
  logic [ADDR_W-1:0]              adj_addr, pick_addr;
  logic                           adj_ok, pick_hit;
  logic [WIN_W-1:0]               pick_win;

  ob_win_regs #(
    .NUM_WIN(NUM_WIN), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_AW(REG_AW)
  ) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (reg_we_i),
    .addr_i (reg_addr_i),
    .wdata_i(reg_wdata_i),
    .rdata_o(reg_rdata_o),
    .range_o(range_w),
    .map_o  (map_w)
  );

  // Borrow out of the subtraction marks an address below the host offset
  assign diff     = {1'b0, xl_addr_i} - {1'b0, HOST_OFFSET};
  assign adj_ok   = ~diff[ADDR_W];
  assign adj_addr = diff[ADDR_W-1:0];

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
    ob_win_match #(
      .ADDR_W(ADDR_W), .MIN_LOG2(MIN_LOG2), .SEL_W(SEL_W), .NSIZES(PAIR_NSIZES[g])
    ) u_match (
      .range_i   (range_w[g]),
      .map_i     (map_w[g]),
      .adj_addr_i(adj_addr),
      .adj_ok_i  (adj_ok),
      .match_o   (match[g]),
      .xl_addr_o (cand_addr[g])
    );
  end

  ob_hit_pick #(
    .NUM_WIN(NUM_WIN), .ADDR_W(ADDR_W), .WIN_W(WIN_W)
  ) u_pick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .match_i(match),
    .addr_i (cand_addr),
    .hit_o  (pick_hit),
    .win_o  (pick_win),
    .addr_o (pick_addr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      xl_valid_o <= 1'b0;
      xl_hit_o   <= 1'b0;
      xl_miss_o  <= 1'b0;
      xl_win_o   <= '0;
      xl_addr_o  <= '0;
    end else begin
      xl_valid_o <= xl_valid_i;
      xl_hit_o   <= xl_valid_i && pick_hit;
      xl_miss_o  <= xl_valid_i && !pick_hit;
      xl_win_o   <= (xl_valid_i && pick_hit) ? pick_win : '0;
      xl_addr_o  <= (xl_valid_i && pick_hit) ? pick_addr : '0;
    end
  end

  assert_below_offset_miss_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xl_valid_i && xl_addr_i < HOST_OFFSET) |=> (xl_miss_o && !xl_hit_o));

  assert_low_bits_pass_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xl_valid_i && pick_hit) |=> (xl_addr_o[MIN_LOG2-1:0] == $past(adj_addr[MIN_LOG2-1:0])));

  assert_miss_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xl_miss_o |-> (xl_addr_o == '0 && xl_win_o == '0 && !xl_hit_o));

  assert_result_latency_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xl_valid_i |=> (xl_valid_o && (xl_hit_o != xl_miss_o)));

  assert_idle_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !xl_valid_i |=> (!xl_valid_o && !xl_hit_o && !xl_miss_o));
endmodule

// File: tb/ob_addr_xlate_tb_top.sv
module ob_addr_xlate_tb_top;
  localparam int unsigned NUM_WIN = 4;
  localparam int unsigned ADDR_W  = 64;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned REG_AW  = 4;
  localparam int unsigned WIN_W   = 2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              reg_we = 1'b0;
  logic [REG_AW-1:0] reg_addr = '0;
  logic [DATA_W-1:0] reg_wdata = '0;
  logic [DATA_W-1:0] reg_rdata;
  logic              xl_valid = 1'b0;
  logic [ADDR_W-1:0] xl_addr = '0;
  logic              xl_valid_o, xl_hit_o, xl_miss_o;
  logic [WIN_W-1:0]  xl_win_o;
  logic [ADDR_W-1:0] xl_addr_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ob_addr_xlate dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .xl_valid_i(xl_valid), .xl_addr_i(xl_addr),
    .xl_valid_o(xl_valid_o), .xl_hit_o(xl_hit_o), .xl_miss_o(xl_miss_o),
    .xl_win_o(xl_win_o), .xl_addr_o(xl_addr_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(input int unsigned a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = REG_AW'(a); reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  // High words first so a window never goes live half-written
  task automatic wr_pair(input int unsigned p, input logic [63:0] rng, input logic [63:0] mp);
    reg_wr(p*4+1, rng[63:32]);
    reg_wr(p*4+3, mp[63:32]);
    reg_wr(p*4+2, mp[31:0]);
    reg_wr(p*4+0, rng[31:0]);
  endtask

  task automatic clear_all();
    for (int p = 0; p < NUM_WIN; p++) wr_pair(p, 64'h0, 64'h0);
  endtask

  task automatic reg_rd(input int unsigned a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    reg_addr = REG_AW'(a);
    #1;
    chk(reg_rdata == exp, tag, 64'(reg_rdata), 64'(exp));
  endtask

  task automatic xlate(input logic [63:0] a, input bit exp_hit, input int unsigned exp_win,
                       input logic [63:0] exp_addr, input string tag);
    logic [3:0] act_f, exp_f;
    @(negedge clk);
    xl_valid = 1'b1; xl_addr = a;
    @(negedge clk);
    xl_valid = 1'b0;
    act_f = {xl_valid_o, xl_hit_o, xl_miss_o, 1'b0};
    exp_f = {1'b1, exp_hit, !exp_hit, 1'b0};
    chk(act_f == exp_f && xl_win_o == WIN_W'(exp_win),
        {tag, " flags/win"}, {56'h0, act_f, 2'b0, xl_win_o}, {56'h0, exp_f, 2'(exp_win)});
    chk(xl_addr_o == exp_addr, {tag, " addr"}, xl_addr_o, exp_addr);
  endtask

  task automatic t_reset();
    chk({xl_valid_o, xl_hit_o, xl_miss_o} == 3'b0 && xl_win_o == '0 && xl_addr_o == '0,
        "R1 outputs after reset", xl_addr_o, 64'h0);
    for (int a = 0; a < NUM_WIN*4; a++) reg_rd(a, 32'h0, "R1 register reads zero");
  endtask

  task automatic t_readback();
    reg_wr(9,  32'hDEAD_BEEF);
    reg_wr(10, 32'h1234_5678);
    reg_wr(11, 32'hCAFE_F00D);
    reg_wr(8,  32'h2000_0004);
    reg_rd(8,  32'h2000_0004, "R2 range lo readback");
    reg_rd(9,  32'hDEAD_BEEF, "R2 range hi readback");
    reg_rd(10, 32'h1234_5678, "R2 map lo readback");
    reg_rd(11, 32'hCAFE_F00D, "R2 map hi readback");
    reg_rd(12, 32'h0, "R2 neighbour pair untouched");
    clear_all();
  endtask

  task automatic t_basic();
    wr_pair(0, 64'h0000_0000_1000_0001, 64'h0000_0020_0000_0000);
    xlate(64'h0000_0000_9123_4560, 1'b1, 0, 64'h0000_0020_0123_4560, "R3 R6 basic hit pair0");
    @(negedge clk);
    chk({xl_valid_o, xl_hit_o, xl_miss_o} == 3'b0, "R10 idle cycle quiet",
        {61'h0, xl_valid_o, xl_hit_o, xl_miss_o}, 64'h0);
  endtask

  task automatic t_offset();
    xlate(64'h0000_0000_1000_0000, 1'b0, 0, 64'h0, "R4 raw base below offset misses");
    xlate(64'h0000_0000_7FFF_FFFF, 1'b0, 0, 64'h0, "R4 just below offset misses");
    xlate(64'h0000_0000_97FF_FFFF, 1'b1, 0, 64'h0000_0020_07FF_FFFF, "R5 top byte of window");
    xlate(64'h0000_0000_9800_0000, 1'b0, 0, 64'h0, "R5 first byte past window");
    xlate(64'h0000_0000_8FFF_FFFF, 1'b0, 0, 64'h0, "R5 byte below window");
  endtask

  task automatic t_size();
    reg_wr(0, 32'h1000_0003);
    xlate(64'h0000_0000_9800_0000, 1'b1, 0, 64'h0000_0020_0800_0000, "R3 select 1 is 256 MiB");
    xlate(64'h0000_0000_A000_0000, 1'b0, 0, 64'h0, "R3 past 256 MiB misses");
  endtask

  task automatic t_unsupported();
    clear_all();
    wr_pair(0, 64'h0000_0000_1000_0005, 64'h0000_0020_0000_0000);
    xlate(64'h0000_0000_9123_4560, 1'b0, 0, 64'h0, "R7 select 2 on pair0 unsupported");
    wr_pair(2, 64'h0000_0000_2000_0005, 64'h0000_0030_0000_0000);
    xlate(64'h0000_0000_BABC_DEF0, 1'b1, 2, 64'h0000_0030_1ABC_DEF0, "R7 select 2 on pair2 512 MiB");
    reg_wr(9, 32'h0000_0001);
    xlate(64'h0000_0000_BABC_DEF0, 1'b0, 0, 64'h0, "R5 high range word compared");
  endtask

  task automatic t_priority();
    clear_all();
    wr_pair(1, 64'h0000_0000_1000_0001, 64'h0000_0040_0000_0000);
    wr_pair(3, 64'h0000_0000_0000_0007, 64'h0000_0050_0000_0000);
    xlate(64'h0000_0000_9123_4560, 1'b1, 1, 64'h0000_0040_0123_4560, "R8 lower pair wins");
    reg_wr(4, 32'h1000_0000);
    xlate(64'h0000_0000_9123_4560, 1'b1, 3, 64'h0000_0050_1123_4560, "R8 R3 disabled pair1 yields pair3");
  endtask

  task automatic t_align();
    reg_wr(12, 32'h0ABC_0007);
    reg_wr(14, 32'h0000_1230);
    xlate(64'h0000_0000_9123_4560, 1'b1, 3, 64'h0000_0050_1123_4560, "R5 R6 low base/map bits ignored");
  endtask

  task automatic t_invalidate();
    reg_wr(12, 32'h0ABC_0006);
    reg_wr(13, 32'h0000_0000);
    xlate(64'h0000_0000_9123_4560, 1'b0, 0, 64'h0, "R9 R3 all disabled gives miss");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_readback();
    t_basic();
    t_offset();
    t_size();
    t_unsupported();
    t_priority();
    t_align();
    t_invalidate();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R10 actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule